// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block holds two independent 16-bit counting units, each kept as a low byte and a high byte, behind a small byte-wide register port. Each unit counts either ticks of a shared divide-by-twelve prescaler (timer mode) or falling edges seen on its own external count pin (counter mode). Counting can be qualified by a per-unit gate pin. A shared configuration register selects, for each unit, one of four layouts: a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads itself, or (unit 0 only) a split into two free 8-bit counters.

When a unit wraps, it sets a sticky overflow flag. Software clears the flag by writing the control register. The flags also appear directly on output pins for use as interrupt requests.

The behaviour is built around a few named states. The prescaler walks through twelve phase states and emits a tick in the last one. Each pin detector is in one of two sampled levels, and it reports an edge on the transition from high to low. Each unit's layout is an enumerated value (`TM_13`, `TM_16`, `TM_RELOAD`, `TM_SPLIT`) that selects its next-count logic.

Top module: `tc_pair`

## Requirements
- R1: After reset every readable register returns 0x00 and both overflow outputs are low.
- R2: Register addresses are: 0 control, 1 mode, 2 unit-0 low, 3 unit-0 high, 4 unit-1 low, 5 unit-1 high; addresses 6 and 7 read 0x00. Control bit 0 is run for unit 0, bit 1 is run for unit 1, bit 4 is the unit-0 overflow flag, bit 5 is the unit-1 overflow flag, and the other control bits read 0. Mode bits [1:0] hold the unit-0 layout (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split), bit 2 selects counter mode for unit 0, and bit 3 is the unit-0 gate bit. Bits [7:4] hold the same fields for unit 1.
- R3: In timer mode an enabled unit advances by exactly one every 12 clock cycles, driven by a prescaler that runs freely from reset.
- R4: A unit counts only when its run bit is 1 and either its gate bit is 0 or its gate pin is high.
- R5: In counter mode an enabled unit advances by one for each high-to-low change of its sampled count pin. Rising edges, steady levels and prescaler ticks have no effect.
- R6: In 16-bit layout a unit wraps from 0xFFFF to 0x0000 and sets its overflow flag in the same cycle.
- R7: In 13-bit layout only bits [4:0] of the low byte count. A carry out of bit 4 increments the high byte, the low byte's bits [7:5] keep their value, and a wrap of the high byte sets the flag.
- R8: In reload layout the low byte counts. When it wraps from 0xFF it takes the value of the high byte, the high byte is unchanged, and the flag is set.
- R9: With unit 0 in split layout, its low byte counts under unit 0's run/gate/mode controls and sets flag 0. Its high byte counts prescaler ticks while run bit 1 is set, and its wraps set flag 1. A unit 1 in split layout holds its value.
- R10: Overflow flags stay set until a control-register write puts 0 in their bit. A hardware set in the same cycle as such a write takes precedence.
- R11: The two units count independently: the pins and run bit of one have no effect on the other's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| count_pin | input | 2 | External count inputs, one per unit |
| gate_pin | input | 2 | External gate inputs, one per unit |
| ovf_flag | output | 2 | Sticky overflow flags, bit i for unit i |

## Verification
The bench measures the distance between successive timer increments. A prescaler off by one shows up as 11- or 13-cycle spacing. Counter tests hold the pin low for many cycles and drive rising edges, so a level-sensitive or edge-confused detector counts too often. The 13-bit and reload tests start just below the wrap point, which catches designs that clear the low byte's upper bits, forget the reload value, or lose the flag. In the split test the bench looks for flag 1 coming from unit 0's high byte while unit 1 stays frozen, and checks that flags survive idle cycles until software clears them.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [1:0] {
        TM_13     = 2'd0,
        TM_16     = 2'd1,
        TM_RELOAD = 2'd2,
        TM_SPLIT  = 2'd3
    } tmode_e;

    localparam int ADDR_W  = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_T0LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_T0HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_T1LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_T1HI = 3'd5;
endpackage

// File: rtl/tc_prescale.sv
module tc_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                    phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);

    // R3: phase never leaves its range, and ticks are never back to back
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);
    p_tick_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tc_edge.sv
module tc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic now_q, old_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= 1'b0;
            old_q <= 1'b0;
        end else begin
            now_q <= pin;
            old_q <= now_q;
        end
    end

    assign fall = old_q & ~now_q;

    // R5: one edge can never be reported on two consecutive cycles
    p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tc_unit.sv
module tc_unit
    import tc_pkg::*;
#(
    parameter int W  = 8,
    parameter int PW = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmode_e       mode,
    input  logic         inc,
    input  logic         inc_hi,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi,
    output logic         ov_main,
    output logic         ov_split
);
    logic [W-1:0] lo_n, hi_n;
    logic [PW:0]  pre_sum;

    always_comb begin
        lo_n     = lo;
        hi_n     = hi;
        ov_main  = 1'b0;
        ov_split = 1'b0;
        pre_sum  = {1'b0, lo[PW-1:0]} + (PW+1)'(1);
        unique case (mode)
            TM_13: begin
                if (inc) begin
                    lo_n[PW-1:0] = pre_sum[PW-1:0];
                    if (pre_sum[PW]) {ov_main, hi_n} = {1'b0, hi} + (W+1)'(1);
                end
            end
            TM_16: begin
                if (inc) {ov_main, hi_n, lo_n} = {1'b0, hi, lo} + (2*W+1)'(1);
            end
            TM_RELOAD: begin
                if (inc) begin
                    if (&lo) begin
                        lo_n    = hi;
                        ov_main = 1'b1;
                    end else begin
                        lo_n = lo + 1'b1;
                    end
                end
            end
            TM_SPLIT: begin
                if (inc)    {ov_main, lo_n}  = {1'b0, lo} + (W+1)'(1);
                if (inc_hi) {ov_split, hi_n} = {1'b0, hi} + (W+1)'(1);
            end
        endcase
        if (wr_lo) lo_n = wdata;
        if (wr_hi) hi_n = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_n;
            hi <= hi_n;
        end
    end

    // R8: a wrap in reload layout loads the high byte into the low byte
    p_reload_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_RELOAD && inc && (&lo) && !wr_lo && !wr_hi)
        |=> (lo == $past(hi)) && $stable(hi));
    // R4: with no count request and no write the value holds
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !inc_hi && !wr_lo && !wr_hi) |=> $stable(lo) && $stable(hi));
    // R7: 13-bit layout never disturbs the upper low-byte bits
    p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_13 && !wr_lo) |=> $stable(lo[W-1:PW]));
endmodule

// File: rtl/tc_pair.sv
module tc_pair
    import tc_pkg::*;
#(
    parameter int W   = 8,
    parameter int DIV = 12,
    parameter int PW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [1:0]        count_pin,
    input  logic [1:0]        gate_pin,
    output logic [1:0]        ovf_flag
);
    localparam int NU = 2;

    logic [NU-1:0] run_q, ovf_q, fall, enable, source;
    logic [W-1:0]  mode_q;
    logic          tick;
    tmode_e        umode [NU];
    logic [NU-1:0] ctsel, gtsel;
    logic [W-1:0]  lo [NU];
    logic [W-1:0]  hi [NU];
    logic [NU-1:0] ov_m, ov_s, inc, inc_hi, wr_lo, wr_hi;
    logic [NU-1:0] set_flag;
    logic          wr_ctrl, wr_mode;

    tc_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_mode = bus_wr && (bus_addr == A_MODE);

    for (genvar i = 0; i < NU; i++) begin : g_unit
        tc_edge u_edge (.clk(clk), .rst_n(rst_n), .pin(count_pin[i]), .fall(fall[i]));

        assign umode[i]  = tmode_e'(mode_q[4*i +: 2]);
        assign ctsel[i]  = mode_q[4*i + 2];
        assign gtsel[i]  = mode_q[4*i + 3];
        assign enable[i] = run_q[i] & (~gtsel[i] | gate_pin[i]);
        assign source[i] = ctsel[i] ? fall[i] : tick;
        assign wr_lo[i]  = bus_wr && (bus_addr == (i == 0 ? A_T0LO : A_T1LO));
        assign wr_hi[i]  = bus_wr && (bus_addr == (i == 0 ? A_T0HI : A_T1HI));

        tc_unit #(.W(W), .PW(PW)) u_cnt (
            .clk(clk), .rst_n(rst_n), .mode(umode[i]),
            .inc(inc[i]), .inc_hi(inc_hi[i]),
            .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(bus_wdata),
            .lo(lo[i]), .hi(hi[i]), .ov_main(ov_m[i]), .ov_split(ov_s[i])
        );
    end

    // unit 0 always follows its own controls; its high byte borrows run 1 when split
    assign inc[0]    = enable[0] & source[0];
    assign inc_hi[0] = (umode[0] == TM_SPLIT) & run_q[1] & tick;
    // unit 1 freezes in split layout
    assign inc[1]    = (umode[1] != TM_SPLIT) & enable[1] & source[1];
    assign inc_hi[1] = 1'b0;

    assign set_flag[0] = ov_m[0];
    assign set_flag[1] = ((umode[0] == TM_SPLIT) ? ov_s[0] : ov_m[1]) | ov_s[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            ovf_q  <= '0;
            mode_q <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q <= bus_wdata[1:0];
                ovf_q <= bus_wdata[5:4] | set_flag;
            end else begin
                ovf_q <= ovf_q | set_flag;
            end
            if (wr_mode) mode_q <= bus_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {2'b00, ovf_q, 2'b00, run_q};
            A_MODE:  bus_rdata = mode_q;
            A_T0LO:  bus_rdata = lo[0];
            A_T0HI:  bus_rdata = hi[0];
            A_T1LO:  bus_rdata = lo[1];
            A_T1HI:  bus_rdata = hi[1];
            default: bus_rdata = '0;
        endcase
    end

    assign ovf_flag = ovf_q;

    // R10: a set flag survives every cycle without a control write
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctrl) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
    // R9: unit 1 in split layout never moves unless written
    p_split_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (umode[1] == TM_SPLIT && !wr_lo[1] && !wr_hi[1])
        |=> $stable(lo[1]) && $stable(hi[1]));
    // R4: a closed run bit means unit 0 never raises its flag
    p_stopped_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q[0] && !wr_ctrl && !ovf_q[0]) |=> !ovf_q[0]);
endmodule

// File: tb/tb_tc_pair.sv
`timescale 1ns/1ps
module tb_tc_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] count_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] ovf_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tc_pair dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_pin(count_pin),
        .gate_pin(gate_pin), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input int i);
        @(negedge clk); count_pin[i] = 1'b0;
        repeat (3) @(negedge clk);
        count_pin[i] = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), d);
            check(d == 8'h00, "R1 reset register", d, 0);
        end
        check(ovf_flag == 2'b00, "R1 reset flags", ovf_flag, 0);
    endtask

    task automatic t_map();
        logic [7:0] d;
        wr_reg(3'd0, 8'hFF);
        rd_reg(3'd0, d);
        check(d == 8'h33, "R2 control bit layout", d, 8'h33);
        wr_reg(3'd0, 8'h00);
        rd_reg(3'd0, d);
        check(d == 8'h00, "R2 control cleared", d, 0);
        wr_reg(3'd1, 8'hA5);
        rd_reg(3'd1, d);
        check(d == 8'hA5, "R2 mode readback", d, 8'hA5);
        wr_reg(3'd6, 8'h77);
        rd_reg(3'd6, d);
        check(d == 8'h00, "R2 unused address", d, 0);
    endtask

    task automatic t_prescale();
        logic [7:0] d, prev;
        int last, changes;
        wr_reg(3'd1, 8'h01);
        wr_reg(3'd2, 8'h00);
        wr_reg(3'd3, 8'h00);
        wr_reg(3'd0, 8'h01);
        rd_reg(3'd2, prev);
        last = -1; changes = 0;
        for (int c = 0; c < 80; c++) begin
            rd_reg(3'd2, d);
            if (d != prev) begin
                check(d == prev + 8'd1, "R3 step of one", d, prev + 1);
                if (last >= 0) check(c - last == 12, "R3 spacing", c - last, 12);
                last = c; changes++; prev = d;
            end
        end
        check(changes >= 6, "R3 number of ticks", changes, 6);
        wr_reg(3'd0, 8'h00);
    endtask

    task automatic t_run_gate();
        logic [7:0] d;
        wr_reg(3'd1, 8'h01);
        wr_reg(3'd2, 8'h00);
        repeat (40) @(negedge clk);
        rd_reg(3'd2, d);
        check(d == 8'h00, "R4 run off holds", d, 0);
        wr_reg(3'd1, 8'h09);
        gate_pin[0] = 1'b0;
        wr_reg(3'd0, 8'h01);
        repeat (40) @(negedge clk);
        rd_reg(3'd2, d);
        check(d == 8'h00, "R4 gate closed holds", d, 0);
        gate_pin[0] = 1'b1;
        repeat (40) @(negedge clk);
        rd_reg(3'd2, d);
        check(d >= 8'd3 && d <= 8'd4, "R4 gate open counts", d, 3);
        wr_reg(3'd0, 8'h00);
        gate_pin[0] = 1'b0;
    endtask

    task automatic t_counter();
        logic [7:0] d;
        wr_reg(3'd1, 8'h05);
        wr_reg(3'd2, 8'h00);
        wr_reg(3'd3, 8'h00);
        wr_reg(3'd0, 8'h01);
        for (int k = 0; k < 5; k++) pulse(0);
        rd_reg(3'd2, d);
        check(d == 8'h05, "R5 five falling edges", d, 5);
        @(negedge clk); count_pin[0] = 1'b0;
        repeat (30) @(negedge clk);
        count_pin[0] = 1'b1;
        repeat (30) @(negedge clk);
        rd_reg(3'd2, d);
        check(d == 8'h06, "R5 long low and rise count once", d, 6);
        wr_reg(3'd0, 8'h00);
    endtask

    task automatic t_wrap16();
        logic [7:0] d;
        wr_reg(3'd1, 8'h05);
        wr_reg(3'd2, 8'hFE);
        wr_reg(3'd3, 8'hFF);
        wr_reg(3'd0, 8'h01);
        pulse(0);
        rd_reg(3'd0, d);
        check(d == 8'h01, "R6 no flag before wrap", d, 1);
        pulse(0);
        rd_reg(3'd2, d);
        check(d == 8'h00, "R6 low wraps", d, 0);
        rd_reg(3'd3, d);
        check(d == 8'h00, "R6 high wraps", d, 0);
        check(ovf_flag == 2'b01, "R6 flag pin", ovf_flag, 1);
        repeat (20) @(negedge clk);
        rd_reg(3'd0, d);
        check(d == 8'h11, "R10 flag sticky", d, 8'h11);
        wr_reg(3'd0, 8'h01);
        rd_reg(3'd0, d);
        check(d == 8'h01, "R10 software clear", d, 1);
        wr_reg(3'd0, 8'h00);
    endtask

    task automatic t_mode13();
        logic [7:0] d;
        wr_reg(3'd1, 8'h04);
        wr_reg(3'd2, 8'h5F);
        wr_reg(3'd3, 8'h12);
        wr_reg(3'd0, 8'h01);
        pulse(0);
        rd_reg(3'd2, d);
        check(d == 8'h40, "R7 carry keeps upper bits", d, 8'h40);
        rd_reg(3'd3, d);
        check(d == 8'h13, "R7 carry into high", d, 8'h13);
        rd_reg(3'd0, d);
        check(d == 8'h01, "R7 no flag on carry", d, 1);
        wr_reg(3'd2, 8'hBF);
        wr_reg(3'd3, 8'hFF);
        pulse(0);
        rd_reg(3'd2, d);
        check(d == 8'hA0, "R7 wrap low", d, 8'hA0);
        rd_reg(3'd3, d);
        check(d == 8'h00, "R7 wrap high", d, 0);
        rd_reg(3'd0, d);
        check(d == 8'h11, "R7 flag on wrap", d, 8'h11);
        wr_reg(3'd0, 8'h00);
    endtask

    task automatic t_reload();
        logic [7:0] d;
        wr_reg(3'd1, 8'h06);
        wr_reg(3'd3, 8'h80);
        wr_reg(3'd2, 8'hFE);
        wr_reg(3'd0, 8'h01);
        pulse(0);
        rd_reg(3'd2, d);
        check(d == 8'hFF, "R8 count to top", d, 8'hFF);
        pulse(0);
        rd_reg(3'd2, d);
        check(d == 8'h80, "R8 reload value", d, 8'h80);
        rd_reg(3'd3, d);
        check(d == 8'h80, "R8 high unchanged", d, 8'h80);
        rd_reg(3'd0, d);
        check(d == 8'h11, "R8 flag", d, 8'h11);
        pulse(0);
        rd_reg(3'd2, d);
        check(d == 8'h81, "R8 counts after reload", d, 8'h81);
        wr_reg(3'd0, 8'h00);
    endtask

    task automatic t_split();
        logic [7:0] d;
        bit seen;
        wr_reg(3'd1, 8'h37);
        wr_reg(3'd2, 8'h10);
        wr_reg(3'd3, 8'hFE);
        wr_reg(3'd4, 8'h55);
        wr_reg(3'd5, 8'h66);
        wr_reg(3'd0, 8'h03);
        seen = 1'b0;
        for (int c = 0; c < 40 && !seen; c++) begin
            rd_reg(3'd0, d);
            if (d[5]) seen = 1'b1;
        end
        check(seen, "R9 high byte sets flag 1", d, 8'h23);
        check(d[4] == 1'b0, "R9 flag 0 untouched", d[4], 0);
        rd_reg(3'd3, d);
        check(d == 8'h00, "R9 high byte wrapped", d, 0);
        rd_reg(3'd2, d);
        check(d == 8'h10, "R9 low byte idle without edges", d, 8'h10);
        pulse(0);
        rd_reg(3'd2, d);
        check(d == 8'h11, "R9 low byte counts edges", d, 8'h11);
        pulse(1);
        rd_reg(3'd4, d);
        check(d == 8'h55, "R9 unit 1 low frozen", d, 8'h55);
        rd_reg(3'd5, d);
        check(d == 8'h66, "R9 unit 1 high frozen", d, 8'h66);
        wr_reg(3'd0, 8'h00);
    endtask

    task automatic t_indep();
        logic [7:0] d;
        wr_reg(3'd1, 8'h50);
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd5, 8'h00);
        wr_reg(3'd2, 8'h33);
        wr_reg(3'd0, 8'h02);
        for (int k = 0; k < 3; k++) pulse(1);
        pulse(0);
        pulse(0);
        rd_reg(3'd4, d);
        check(d == 8'h03, "R11 unit 1 counts own pin", d, 3);
        rd_reg(3'd2, d);
        check(d == 8'h33, "R11 unit 0 unaffected", d, 8'h33);
        wr_reg(3'd0, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_prescale();
        t_run_gate();
        t_counter();
        t_wrap16();
        t_mode13();
        t_reload();
        t_split();
        t_indep();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule